// File: doc/BRIEF.md
# SPI Command Word Receiver

This block is the slave end of a write-only SPI link. Each time chip select is asserted, it collects one 16-bit word from the serial data line. The word is split into a 4-bit command and a 12-bit operand. All three serial inputs are oversampled by the system clock through synchronizers, so the whole block runs in the system clock domain. When a word is complete, the block shows the command and operand on its outputs and pulses a valid strobe for one system clock cycle.

One command code is reserved for configuration. A word that carries this code also loads a persistent mode register from the low operand bits. The mode register is exposed as an output so that the surrounding logic can select its operating mode. Every other command code is passed out on the command/operand/strobe interface and is not interpreted.

Top module: `cmdword_rx`

## Requirements
- R1: A frame is 16 bits sent most significant bit first; the first bit sampled after chip select falls becomes bit 15 of the word.
- R2: Word bits 15 to 12 appear on `cmd_o` and bits 11 to 0 appear on `data_o`.
- R3: The serial clock idles low and `spi_mosi` is sampled only on its rising edge; changes of `spi_mosi` while the serial clock is low have no effect.
- R4: Each complete frame raises `valid_o` for exactly one system clock cycle, with `cmd_o` and `data_o` already showing that frame.
- R5: If chip select rises before 16 bits have arrived, the partial frame is discarded, no strobe is produced, and the next frame starts again at bit 15.
- R6: Rising edges of the serial clock after the 16th, within the same chip select assertion, are ignored and produce no further strobe.
- R7: Serial clock activity while chip select (`spi_cs_n`, active low) is high is ignored.
- R8: A frame with command code 4'h1 loads `mode_o` from operand bits 7 to 0 in the same cycle that `valid_o` rises; operand bits 11 to 8 are ignored.
- R9: A frame with any other command code is still presented with a strobe and leaves `mode_o` unchanged.
- R10: After reset, `valid_o` is 0 and `cmd_o`, `data_o` and `mode_o` are all zero.
- R11: `cmd_o` and `data_o` keep the last received frame until the next complete frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the master, idle low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_cs_n | input | 1 | Active-low chip select, framing one word |
| cmd_o | output | 4 | Command field of the last complete word |
| data_o | output | 12 | Operand field of the last complete word |
| valid_o | output | 1 | One-cycle strobe when a new word is complete |
| mode_o | output | 8 | Mode register, loaded by the configuration command |

## Verification
The assertions assume that each level of the serial clock lasts at least two system clock cycles. They also assume that the serial data and chip select lines change only while the serial clock is low, so the synchronized view never sees data move at a sampling edge. The stimulus keeps each serial clock half period at three system clock cycles. It changes data and chip select only in the low phase, and it places several idle cycles between frames. Within these limits, the stimulus covers short frames, overlong frames and clocking while chip select is high.

// File: rtl/cmdword_pkg.sv
package cmdword_pkg;
    localparam int unsigned CW_FRAME_W  = 16;
    localparam int unsigned CW_CMD_W    = 4;
    localparam int unsigned CW_CFG_W    = 8;
    localparam logic [3:0]  CW_CFG_CODE = 4'h1;
endpackage

// File: rtl/cw_sync.sv
module cw_sync #(
    parameter int unsigned WIDTH   = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= RST_VAL;
                    else        stage_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= RST_VAL;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/cw_shifter.sv
module cw_shifter #(
    parameter int unsigned FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sck_s,
    input  logic               mosi_s,
    input  logic               cs_n_s,
    output logic               done_o,
    output logic [FRAME_W-1:0] word_o
);
    localparam int unsigned CNT_W = $clog2(FRAME_W + 1);

    typedef struct packed {
        logic               sck_prev;
        logic [CNT_W-1:0]   count;
        logic [FRAME_W-1:0] shreg;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic         rise;

    always_comb begin
        st_d          = st_q;
        st_d.sck_prev = sck_s;
        rise          = sck_s && !st_q.sck_prev && !cs_n_s;
        done_o        = 1'b0;
        word_o        = {st_q.shreg[FRAME_W-2:0], mosi_s};
        if (cs_n_s) begin
            st_d.count = '0;
        end else if (rise && (st_q.count < CNT_W'(FRAME_W))) begin
            st_d.shreg = {st_q.shreg[FRAME_W-2:0], mosi_s};
            st_d.count = st_q.count + 1'b1;
            done_o     = (st_q.count == CNT_W'(FRAME_W - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CNT_W'(FRAME_W));

    assert_idle_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |-> !done_o);

    assert_count_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (st_q.count == '0));
endmodule

// File: rtl/cmdword_rx.sv
module cmdword_rx
    import cmdword_pkg::*;
#(
    parameter int unsigned FRAME_W     = CW_FRAME_W,
    parameter int unsigned CMD_W       = CW_CMD_W,
    parameter int unsigned CFG_W       = CW_CFG_W,
    parameter logic [CMD_W-1:0] CFG_CODE = CW_CFG_CODE,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       spi_sck,
    input  logic                       spi_mosi,
    input  logic                       spi_cs_n,
    output logic [CMD_W-1:0]           cmd_o,
    output logic [FRAME_W-CMD_W-1:0]   data_o,
    output logic                       valid_o,
    output logic [CFG_W-1:0]           mode_o
);
    localparam int unsigned DATA_W = FRAME_W - CMD_W;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [DATA_W-1:0] data;
        logic              valid;
        logic [CFG_W-1:0]  mode;
    } rx_state_t;

    rx_state_t          st_d, st_q;
    logic [2:0]         pins_s;
    logic               done;
    logic [FRAME_W-1:0] word;

    cw_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({spi_cs_n, spi_mosi, spi_sck}),
        .sync_o  (pins_s)
    );

    cw_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s   (pins_s[0]),
        .mosi_s  (pins_s[1]),
        .cs_n_s  (pins_s[2]),
        .done_o  (done),
        .word_o  (word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = done;
        if (done) begin
            st_d.cmd  = word[FRAME_W-1 -: CMD_W];
            st_d.data = word[DATA_W-1:0];
            if (word[FRAME_W-1 -: CMD_W] == CFG_CODE) begin
                st_d.mode = word[CFG_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmd_o   = st_q.cmd;
    assign data_o  = st_q.data;
    assign valid_o = st_q.valid;
    assign mode_o  = st_q.mode;

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_mode_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && cmd_o == CFG_CODE) |-> (mode_o == data_o[CFG_W-1:0]));

    assert_mode_only_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> (valid_o && cmd_o == CFG_CODE));

    assert_fields_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(data_o) && $stable(cmd_o)));
endmodule

// File: tb/cmdword_rx_bench.sv
module cmdword_rx_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF_SCK   = 3;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        spi_sck = 1'b0;
    logic        spi_mosi = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic [3:0]  cmd_o;
    logic [11:0] data_o;
    logic        valid_o;
    logic [7:0]  mode_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit running  = 1'b0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    logic [7:0]  model_mode = 8'h00;
    logic [3:0]  last_cmd   = 4'h0;
    logic [11:0] last_data  = 12'h000;
    int          strobes    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmdword_rx u_cmdword_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .spi_sck  (spi_sck),
        .spi_mosi (spi_mosi),
        .spi_cs_n (spi_cs_n),
        .cmd_o    (cmd_o),
        .data_o   (data_o),
        .valid_o  (valid_o),
        .mode_o   (mode_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    // Sends nbits of word MSB first; a full frame is queued at the 16th rise.
    task automatic send_bits(input logic [31:0] word, input int nbits);
        spi_cs_n = 1'b0;
        wait_clk(HALF_SCK);
        for (int i = 0; i < nbits; i++) begin
            spi_mosi = word[nbits-1-i];
            wait_clk(HALF_SCK);
            spi_sck = 1'b1;
            if (i == 15) exp_q.push_back(16'(word >> (nbits - 16)));
            wait_clk(HALF_SCK);
            spi_sck = 1'b0;
            spi_mosi = ~spi_mosi;   // R3: toggled while clock is low
        end
        wait_clk(HALF_SCK);
        spi_cs_n = 1'b1;
        wait_clk(10);
    endtask

    task automatic idle_clocking(input int n);
        for (int i = 0; i < n; i++) begin
            spi_mosi = i[0];
            wait_clk(HALF_SCK);
            spi_sck = 1'b1;
            wait_clk(HALF_SCK);
            spi_sck = 1'b0;
        end
        wait_clk(10);
    endtask

    // Reference model compared on every clock.
    always @(negedge clk) begin
        if (running) begin
            if (valid_o) begin
                strobes++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4/R5/R6/R7 unexpected strobe", 1, 0);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    check(cmd_o == e[15:12], "R1/R2 cmd", cmd_o, e[15:12]);
                    check(data_o == e[11:0], "R1/R2 data", data_o, e[11:0]);
                    if (e[15:12] == 4'h1) model_mode = e[7:0];
                    last_cmd  = e[15:12];
                    last_data = e[11:0];
                end
            end else begin
                check(cmd_o == last_cmd, "R11 cmd hold", cmd_o, last_cmd);
                check(data_o == last_data, "R11 data hold", data_o, last_data);
            end
            check(mode_o == model_mode, "R8/R9 mode", mode_o, model_mode);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        wait_clk(5);
        check(valid_o == 1'b0, "R10 valid", valid_o, 0);
        check(mode_o == 8'h00, "R10 mode", mode_o, 0);
        check(cmd_o == 4'h0, "R10 cmd", cmd_o, 0);
        check(data_o == 12'h000, "R10 data", data_o, 0);
        rst_n = 1'b1;
        wait_clk(5);
        running = 1'b1;

        send_bits(32'h1A5C, 16);          // R8 config load
        send_bits(32'h7123, 16);          // R9 other opcode
        send_bits(32'h00B5, 8);           // R5 short frame discarded
        check(exp_q.size() == 0 && strobes == 2, "R5 strobes", strobes, 2);
        send_bits(32'h2ABC, 16);          // R5 restarts at bit 15
        send_bits(32'hF0FF_3, 20);        // R6 extra bits ignored
        check(strobes == 4, "R6 strobes", strobes, 4);
        idle_clocking(12);                // R7 clocks with chip select high
        check(strobes == 4, "R7 strobes", strobes, 4);
        send_bits(32'hFFFF, 16);
        send_bits(32'h0000, 16);
        send_bits(32'h1300, 16);          // R8 high operand bits ignored
        send_bits(32'h8001, 16);          // R9
        send_bits(32'h1FE7, 16);          // R8

        check(exp_q.size() == 0, "R4 missing strobe", exp_q.size(), 0);
        check(strobes == 9, "R4 strobe count", strobes, 9);
        check(mode_o == 8'hE7, "R8 final mode", mode_o, 8'hE7);
        running = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule